// File: doc/BRIEF.md
# LPC Host Controller Register Bank

This block is the 32-bit register bank that sits behind the local register bus of an LPC host controller. It holds the firmware segment select, the firmware read access size, the serial-IRQ control word and the interrupt mask. It also keeps an interrupt status word and a read-only error address. The bus is a simple word-wide port. A write takes effect at the clock edge where select and write-enable are both high. Read data is combinational from the address while select is high, and reads have no side effects.

Hardware raises status bits through one event-pulse input per bit. Software clears them by writing ones to the status register. The bank drives a single interrupt line that goes high whenever any unmasked status bit is set. When a bus error or sync cause fires, the bank captures the address presented on an error-address input at the same edge.

Top module: `lpchc_regbank`

## Requirements
- R1: After synchronous reset the firmware read-size register reads 0x02000000 (the 4-byte code; 1 byte is 0x00000000, 2 bytes 0x01000000, 16 bytes 0x04000000, 128 bytes 0x07000000). Every other register reads 0 and `irq` is low.
- R2: The firmware segment select (offset 0x24), the read-size (0x28) and the serial-IRQ control (0x30) registers read back all 32 written bits. In the serial-IRQ control register, bit 31 is enable, bit 30 is quiet mode and bits [25:24] select a start frame of 4, 6 or 8 clocks as codes 0, 1 and 2. The mask register (0x34) reads back the written value ANDed with 0xFFFF84FF.
- R3: A one on `evt_set[i]` sets status bit i (offset 0x38) at the next edge for every implemented bit. The implemented bits are [31:15] for serial IRQ 0..16, bit 10 for LPC reset, bits 7..4 for abnormal sync, no-response, normal sync error and timeout, bits 3..2 for target and bus-master turnaround errors, and bits 1..0 for bus-master requests. All other status bits always read 0.
- R4: A write to the status register clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R6: `irq` is high exactly when (status AND mask) is nonzero.
- R7: An event on any of status bits 7..2 loads `err_addr_in` into the error address register (0x40). Events on other bits leave it unchanged.
- R8: Writes to the error address register have no effect.
- R9: Reads of any other offset, including non-word-aligned ones, return 0xFFFFFFFF. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected |
| evt_set | input | 32 | Per-bit status set pulses |
| err_addr_in | input | 32 | Address captured on an error event |
| irq | output | 1 | Masked interrupt summary |

## Verification
The bench sweeps all 32 event lines one at a time. A bank that latches reserved bits, drops a serial-IRQ line or captures the error address on the wrong causes would show a stray or missing status bit, or a moved error address. It reads every word offset of the 4 KiB window and some unaligned ones, where a loose decoder would alias a register into the hole. It drives a set and a clear onto the same bit in one cycle; getting the priority backwards leaves the bit at zero. It writes zeros to the status register, which a plain overwrite would treat as a clear. It also writes to the read-only and unmapped offsets and reads back every register, so any decode that leaks a write shows up as a changed value.

// File: rtl/lpchc_pkg.sv
package lpchc_pkg;

    localparam int DW = 32;

    localparam logic [31:0] OFF_FWSEG   = 32'h24;
    localparam logic [31:0] OFF_FWSIZE  = 32'h28;
    localparam logic [31:0] OFF_SIRQ    = 32'h30;
    localparam logic [31:0] OFF_MASK    = 32'h34;
    localparam logic [31:0] OFF_STAT    = 32'h38;
    localparam logic [31:0] OFF_ERRADDR = 32'h40;

    // implemented status / mask bits
    localparam logic [DW-1:0] STAT_VALID   = 32'hFFFF_84FF;
    // error and sync causes that load the error address
    localparam logic [DW-1:0] ERR_CAUSES   = 32'h0000_00FC;
    localparam logic [DW-1:0] FWSIZE_RESET = 32'h0200_0000;
    localparam logic [DW-1:0] UNMAPPED_VAL = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FWSEG,
        SEL_FWSIZE,
        SEL_SIRQ,
        SEL_MASK,
        SEL_STAT,
        SEL_ERRADDR
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] fwseg;
        logic [DW-1:0] fwsize;
        logic [DW-1:0] sirq;
        logic [DW-1:0] mask;
    } cfg_regs_t;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            OFF_FWSEG:   return SEL_FWSEG;
            OFF_FWSIZE:  return SEL_FWSIZE;
            OFF_SIRQ:    return SEL_SIRQ;
            OFF_MASK:    return SEL_MASK;
            OFF_STAT:    return SEL_STAT;
            OFF_ERRADDR: return SEL_ERRADDR;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lpchc_decode.sv
module lpchc_decode
    import lpchc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] addr_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_ext = {{PAD_W{1'b0}}, addr};
        end else begin : g_nopad
            assign addr_ext = addr[31:0];
        end
    endgenerate

    always_comb sel = decode_offset(addr_ext);

endmodule

// File: rtl/lpchc_status.sv
module lpchc_status
    import lpchc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] set_pulse,
    input  logic [DW-1:0] clr_bits,
    output logic [DW-1:0] stat
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (STAT_VALID[i]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst)               stat[i] <= 1'b0;
                else if (set_pulse[i]) stat[i] <= 1'b1;
                else if (clr_bits[i])  stat[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign stat[i] = 1'b0;
        end
    end

    // R3: a pulse on an implemented bit shows at the next edge
    a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
        |(set_pulse & STAT_VALID) |=>
            ((stat & $past(set_pulse & STAT_VALID)) == $past(set_pulse & STAT_VALID)));

    // R3: reserved positions never read as one
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (stat & ~STAT_VALID) == '0);

    // R4: a bit only falls where software wrote a one
    a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat) & ~stat & ~$past(clr_bits)) == '0));

endmodule

// File: rtl/lpchc_errcap.sv
module lpchc_errcap
    import lpchc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] events,
    input  logic [DW-1:0] addr_in,
    output logic [DW-1:0] err_addr
);
    logic hit;

    always_comb hit = |(events & ERR_CAUSES);

    always_ff @(posedge clk) begin
        if (rst)      err_addr <= '0;
        else if (hit) err_addr <= addr_in;
    end

    // R7/R8: the captured address moves only on an error cause
    a_r8_hold_without_cause: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(err_addr));

    // R7: an error cause loads the presented address
    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        hit |=> (err_addr == $past(addr_in)));

endmodule

// File: rtl/lpchc_regbank.sv
module lpchc_regbank
    import lpchc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     evt_set,
    input  logic [DW-1:0]     err_addr_in,
    output logic              irq
);
    reg_sel_e      sel;
    cfg_regs_t     cfg;
    logic          wr;
    logic [DW-1:0] stat;
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] err_addr;

    lpchc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb wr = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.fwseg  <= '0;
            cfg.fwsize <= FWSIZE_RESET;
            cfg.sirq   <= '0;
            cfg.mask   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_FWSEG:  cfg.fwseg  <= bus_wdata;
                SEL_FWSIZE: cfg.fwsize <= bus_wdata;
                SEL_SIRQ:   cfg.sirq   <= bus_wdata;
                SEL_MASK:   cfg.mask   <= bus_wdata & STAT_VALID;
                default:    ;
            endcase
        end
    end

    always_comb clr_bits = (wr && sel == SEL_STAT) ? bus_wdata : '0;

    lpchc_status u_status (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_set),
        .clr_bits  (clr_bits),
        .stat      (stat)
    );

    lpchc_errcap u_errcap (
        .clk      (clk),
        .rst      (rst),
        .events   (evt_set),
        .addr_in  (err_addr_in),
        .err_addr (err_addr)
    );

    always_comb irq = |(stat & cfg.mask);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (sel)
                SEL_FWSEG:   bus_rdata = cfg.fwseg;
                SEL_FWSIZE:  bus_rdata = cfg.fwsize;
                SEL_SIRQ:    bus_rdata = cfg.sirq;
                SEL_MASK:    bus_rdata = cfg.mask;
                SEL_STAT:    bus_rdata = stat;
                SEL_ERRADDR: bus_rdata = err_addr;
                default:     bus_rdata = UNMAPPED_VAL;
            endcase
        end
    end

    // R6: the summary line needs some status bit behind it
    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|stat));

    // R2: mask never holds unimplemented bits
    a_r2_mask_legal: assert property (@(posedge clk) disable iff (rst)
        (cfg.mask & ~STAT_VALID) == '0);

    // R1: a cycle after reset the read-size register holds the 4-byte code
    a_r1_size_default: assert property (@(posedge clk)
        $fell(rst) |-> (cfg.fwsize == FWSIZE_RESET));

endmodule

// File: tb/lpchc_regbank_test.sv
module lpchc_regbank_test;

    localparam logic [31:0] VALID = 32'hFFFF_84FF;
    localparam logic [31:0] ERRS  = 32'h0000_00FC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_set = '0;
    logic [31:0] err_addr_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lpchc_regbank #(.ADDR_W(12)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .err_addr_in(err_addr_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic pulse(input logic [31:0] e, input logic [31:0] ea);
        @(negedge clk);
        evt_set = e; err_addr_in = ea;
        @(negedge clk);
        evt_set = '0;
    endtask

    function automatic logic [31:0] exp_read(input int off, input logic [31:0] seg,
        input logic [31:0] sz, input logic [31:0] sq, input logic [31:0] mk,
        input logic [31:0] st, input logic [31:0] ea);
        case (off)
            'h24: return seg;
            'h28: return sz;
            'h30: return sq;
            'h34: return mk;
            'h38: return st;
            'h40: return ea;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_err;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(12'h28, d); check("R1 fwsize", d, 32'h0200_0000);
        rd(12'h24, d); check("R1 fwseg", d, 0);
        rd(12'h30, d); check("R1 sirq", d, 0);
        rd(12'h34, d); check("R1 mask", d, 0);
        rd(12'h38, d); check("R1 stat", d, 0);
        rd(12'h40, d); check("R1 erraddr", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 readback, all size codes and serial-irq fields
        wr(12'h24, 32'hA5C3_1E0F); rd(12'h24, d); check("R2 fwseg", d, 32'hA5C3_1E0F);
        for (int k = 0; k < 5; k++) begin
            logic [31:0] code;
            code = (k == 0) ? 32'h0 : (k == 1) ? 32'h0100_0000 : (k == 2) ? 32'h0200_0000 :
                   (k == 3) ? 32'h0400_0000 : 32'h0700_0000;
            wr(12'h28, code); rd(12'h28, d); check("R2 fwsize code", d, code);
        end
        for (int s = 0; s < 3; s++) begin
            logic [31:0] v;
            v = 32'hC000_0000 | (32'(s) << 24);
            wr(12'h30, v); rd(12'h30, d); check("R2 sirq", d, v);
        end
        wr(12'h34, 32'hFFFF_FFFF); rd(12'h34, d); check("R2 mask filter", d, VALID);

        // R3 R6 R7 R4: sweep every event line with full mask
        exp_err = 0;
        for (int i = 0; i < 32; i++) begin
            logic [31:0] b;
            b = 32'h1 << i;
            pulse(b, 32'h1000_0000 + 32'(i) * 32'h111);
            if ((b & ERRS) != 0) exp_err = 32'h1000_0000 + 32'(i) * 32'h111;
            rd(12'h38, d); check("R3 set sweep", d, b & VALID);
            check("R6 irq sweep", {31'b0, irq}, {31'b0, (b & VALID) != 0});
            rd(12'h40, d); check("R7 capture sweep", d, exp_err);
            wr(12'h38, b);
            rd(12'h38, d); check("R4 clear sweep", d, 0);
            check("R6 irq cleared", {31'b0, irq}, 0);
        end

        // R4 zero bits untouched
        pulse(32'h8000_0001, 32'h0);
        wr(12'h38, 32'h0000_0001);
        rd(12'h38, d); check("R4 zeros keep", d, 32'h8000_0000);

        // R6 masked-off status does not interrupt
        wr(12'h34, 32'h0000_0001);
        check("R6 masked", {31'b0, irq}, 0);
        wr(12'h34, 32'h8000_0000);
        check("R6 unmasked", {31'b0, irq}, 1);

        // R5 set beats clear in same cycle
        @(negedge clk);
        evt_set = 32'h0000_8000;
        bus_sel = 1; bus_we = 1; bus_addr = 12'h38; bus_wdata = 32'h8000_8000;
        @(negedge clk);
        evt_set = 0; bus_sel = 0; bus_we = 0;
        rd(12'h38, d); check("R5 set wins", d, 32'h0000_8000);

        // R8 error address is read-only
        wr(12'h40, 32'h1234_5678);
        rd(12'h40, d); check("R8 erraddr ro", d, exp_err);

        // R9 unmapped writes ignored, then full offset sweep
        wr(12'h2C, 32'h0);
        wr(12'h25, 32'h0);
        wr(12'hFFC, 32'h0);
        for (int o = 0; o < 4096; o += 4) begin
            rd(12'(o), d);
            check("R9 offset sweep", d, exp_read(o, 32'hA5C3_1E0F, 32'h0700_0000,
                  32'hC200_0000, 32'h8000_0000, 32'h0000_8000, exp_err));
        end
        rd(12'h25, d); check("R9 unaligned", d, 32'hFFFF_FFFF);
        rd(12'h3A, d); check("R9 unaligned", d, 32'hFFFF_FFFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule